// File: doc/BRIEF.md
# Three-Port Word Exchanger with Per-Port Input Storage

The block moves 16-bit words among three ports, named A, B and C. A storage stage sits on each port's input. Depending on how that port's controls are set, the stage passes the live input straight through, holds a word it captured earlier, or loads a new word on a rising edge of the port's own clock. A port clock edge only counts when that port's active-low clock enable is asserted.

Each port also has an output side. It drives the stage output of one of the other two ports, chosen by a 1-bit select. Because the selects are independent, one port's word can go to both of its neighbours in the same cycle. Stored words and live words can also be mixed freely across the three ports.

Tri-state buses are not used. Each port has a separate input vector, output vector and active-high drive flag. The drive flag shows where a pad would leave its output floating. All sequential logic runs on a single system clock. Each port clock is treated as a level input, sampled on that system clock, and its rising edges are detected from those samples.

Top module: `tri_port_exchanger`

## Requirements
- R1: While rst_n is low, all three stored words are zero. The remembered level of each port clock is forced high, so a rising edge is only seen after that clock has been sampled low following reset.
- R2: While a port's le is high, its stage output equals that port's live din in the same cycle. On every system clock edge during that time, din is also loaded into the stored word.
- R3: After le goes low, the stage output keeps the word loaded at the last system edge on which le was high, until a clocked capture replaces it.
- R4: With le low and ce_n low, a port clock sampled low on one system edge and high on the next loads din on that second edge. The new word appears at the stage output once that edge has passed.
- R5: With le low and ce_n high, rising edges of the port clock leave the stored word unchanged.
- R6: With le low, a port clock held steady (high or low) leaves the stored word unchanged, whatever din and ce_n do.
- R7: Select encoding: for port A, sel=0 picks B and sel=1 picks C. For port B, sel=0 picks C and sel=1 picks A. For port C, sel=0 picks A and sel=1 picks B.
- R8: One port's stage output can be driven onto both other ports in the same cycle, for example B with sel=1 and C with sel=0 both carrying A.
- R9: When oe_n is high, that port's drive flag is 0 and its dout is all zeros. When oe_n is low, the drive flag is 1 and dout carries the selected word.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| a_din | input | 16 | Port A input word |
| a_le | input | 1 | Port A transparent enable |
| a_pclk | input | 1 | Port A capture clock (sampled level) |
| a_ce_n | input | 1 | Port A capture enable, active low |
| a_sel | input | 1 | Port A source select |
| a_oe_n | input | 1 | Port A output enable, active low |
| a_dout | output | 16 | Port A output word |
| a_drive | output | 1 | Port A drive flag (0 = floating) |
| b_din | input | 16 | Port B input word |
| b_le | input | 1 | Port B transparent enable |
| b_pclk | input | 1 | Port B capture clock (sampled level) |
| b_ce_n | input | 1 | Port B capture enable, active low |
| b_sel | input | 1 | Port B source select |
| b_oe_n | input | 1 | Port B output enable, active low |
| b_dout | output | 16 | Port B output word |
| b_drive | output | 1 | Port B drive flag |
| c_din | input | 16 | Port C input word |
| c_le | input | 1 | Port C transparent enable |
| c_pclk | input | 1 | Port C capture clock (sampled level) |
| c_ce_n | input | 1 | Port C capture enable, active low |
| c_sel | input | 1 | Port C source select |
| c_oe_n | input | 1 | Port C output enable, active low |
| c_dout | output | 16 | Port C output word |
| c_drive | output | 1 | Port C drive flag |

## Verification
Two things can happen in the same system cycle on one port: a port clock rising edge with ce_n low, and le held high. The bench makes this happen by toggling the port clocks while le is high, both in the transparent phase and in a long random phase. In that case the transparent load must take priority, and a clocked capture must not follow on top of it. A behavioural model of the stored words and the clock history is updated on each system edge, and all three outputs are compared with it in the middle of every cycle. This comparison also shows that a capture on one port is visible in the next cycle on any neighbour that selects that port.

// File: rtl/ubx_pkg.sv
package ubx_pkg;

   localparam int unsigned NPORTS = 3;

   typedef enum logic {
      SEL_NEXT = 1'b0,
      SEL_PREV = 1'b1
   } sel_e;

   // index of the neighbour that port p reads for a given select
   function automatic int unsigned src_of(input int unsigned p, input logic sel);
      if (sel == SEL_NEXT) return (p + 1) % NPORTS;
      return (p + NPORTS - 1) % NPORTS;
   endfunction

endpackage

// File: rtl/ubx_edge.sv
module ubx_edge #(
   parameter int unsigned SYNC_STAGES = 0
) (
   input  logic clk,
   input  logic rst_n,
   input  logic lvl_i,
   output logic rise_o
);

   logic lvl_s;
   logic prev_q;

   generate
      if (SYNC_STAGES == 0) begin : g_direct
         assign lvl_s = lvl_i;
      end else begin : g_sync
         logic [SYNC_STAGES-1:0] chain_q;
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) chain_q <= '1;
            else        chain_q <= {chain_q[SYNC_STAGES-1:0], lvl_i} >> 0;
         end
         assign lvl_s = chain_q[SYNC_STAGES-1];
      end
      if (SYNC_STAGES > 4) begin : g_bad_stages
         $error("ubx_edge: SYNC_STAGES above 4 is not supported");
      end
   endgenerate

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) prev_q <= 1'b1;
      else        prev_q <= lvl_s;
   end

   assign rise_o = lvl_s & ~prev_q;

   // R1
   // a rise needs a low sample first, so none can appear straight out of reset
   no_rise_twice_chk: assert property (@(posedge clk) disable iff (!rst_n)
      rise_o |=> !rise_o || !$stable(lvl_s));

endmodule

// File: rtl/ubx_store.sv
module ubx_store #(
   parameter int unsigned W           = 16,
   parameter int unsigned SYNC_STAGES = 0
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic [W-1:0] din_i,
   input  logic         le_i,
   input  logic         pclk_i,
   input  logic         ce_n_i,
   output logic [W-1:0] sto_o
);

   logic [W-1:0] word_q;
   logic         rise;
   logic         load;

   ubx_edge #(.SYNC_STAGES(SYNC_STAGES)) u_edge (
      .clk    (clk),
      .rst_n  (rst_n),
      .lvl_i  (pclk_i),
      .rise_o (rise)
   );

   // transparent level wins over a same-cycle clock edge
   assign load = le_i | (rise & ~ce_n_i);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)    word_q <= '0;
      else if (load) word_q <= din_i;
   end

   assign sto_o = le_i ? din_i : word_q;

   // R2
   transparent_load_chk: assert property (@(posedge clk) disable iff (!rst_n)
      le_i |=> word_q == $past(din_i));

   // R4
   edge_capture_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (!le_i && !ce_n_i && rise) |=> word_q == $past(din_i));

   // R5
   gated_edge_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (!le_i && ce_n_i) |=> $stable(word_q));

   // R6
   still_clock_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (!le_i && !rise) |=> $stable(word_q));

endmodule

// File: rtl/ubx_route.sv
module ubx_route #(
   parameter int unsigned W         = 16,
   parameter bit          PARK_ZERO = 1'b1
) (
   input  logic         sel_i,
   input  logic         oe_n_i,
   input  logic [W-1:0] nxt_i,
   input  logic [W-1:0] prv_i,
   output logic [W-1:0] dout_o,
   output logic         drive_o
);

   logic [W-1:0] picked;

   always_comb begin
      if (sel_i == ubx_pkg::SEL_NEXT) picked = nxt_i;
      else                            picked = prv_i;
   end

   assign drive_o = ~oe_n_i;

   generate
      if (PARK_ZERO) begin : g_park
         assign dout_o = oe_n_i ? '0 : picked;
      end else begin : g_pass
         assign dout_o = picked;
      end
   endgenerate

endmodule

// File: rtl/tri_port_exchanger.sv
module tri_port_exchanger #(
   parameter int unsigned W           = 16,
   parameter int unsigned SYNC_STAGES = 0,
   parameter bit          PARK_ZERO   = 1'b1
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic [W-1:0] a_din,
   input  logic         a_le,
   input  logic         a_pclk,
   input  logic         a_ce_n,
   input  logic         a_sel,
   input  logic         a_oe_n,
   output logic [W-1:0] a_dout,
   output logic         a_drive,
   input  logic [W-1:0] b_din,
   input  logic         b_le,
   input  logic         b_pclk,
   input  logic         b_ce_n,
   input  logic         b_sel,
   input  logic         b_oe_n,
   output logic [W-1:0] b_dout,
   output logic         b_drive,
   input  logic [W-1:0] c_din,
   input  logic         c_le,
   input  logic         c_pclk,
   input  logic         c_ce_n,
   input  logic         c_sel,
   input  logic         c_oe_n,
   output logic [W-1:0] c_dout,
   output logic         c_drive
);

   localparam int unsigned NP = ubx_pkg::NPORTS;

   generate
      if (W < 1) begin : g_bad_w
         $error("tri_port_exchanger: W must be at least 1");
      end
   endgenerate

   logic [W-1:0] din_v  [NP];
   logic [W-1:0] sto_v  [NP];
   logic [W-1:0] dout_v [NP];
   logic         le_v   [NP];
   logic         pclk_v [NP];
   logic         ce_n_v [NP];
   logic         sel_v  [NP];
   logic         oe_n_v [NP];
   logic         drv_v  [NP];

   assign din_v[0] = a_din;  assign din_v[1] = b_din;  assign din_v[2] = c_din;
   assign le_v[0]  = a_le;   assign le_v[1]  = b_le;   assign le_v[2]  = c_le;
   assign pclk_v[0] = a_pclk; assign pclk_v[1] = b_pclk; assign pclk_v[2] = c_pclk;
   assign ce_n_v[0] = a_ce_n; assign ce_n_v[1] = b_ce_n; assign ce_n_v[2] = c_ce_n;
   assign sel_v[0] = a_sel;  assign sel_v[1] = b_sel;  assign sel_v[2] = c_sel;
   assign oe_n_v[0] = a_oe_n; assign oe_n_v[1] = b_oe_n; assign oe_n_v[2] = c_oe_n;

   generate
      for (genvar p = 0; p < NP; p++) begin : g_port
         localparam int unsigned NXT = ubx_pkg::src_of(p, 1'b0);
         localparam int unsigned PRV = ubx_pkg::src_of(p, 1'b1);

         ubx_store #(.W(W), .SYNC_STAGES(SYNC_STAGES)) u_store (
            .clk    (clk),
            .rst_n  (rst_n),
            .din_i  (din_v[p]),
            .le_i   (le_v[p]),
            .pclk_i (pclk_v[p]),
            .ce_n_i (ce_n_v[p]),
            .sto_o  (sto_v[p])
         );

         ubx_route #(.W(W), .PARK_ZERO(PARK_ZERO)) u_route (
            .sel_i   (sel_v[p]),
            .oe_n_i  (oe_n_v[p]),
            .nxt_i   (sto_v[NXT]),
            .prv_i   (sto_v[PRV]),
            .dout_o  (dout_v[p]),
            .drive_o (drv_v[p])
         );
      end
   endgenerate

   assign a_dout = dout_v[0]; assign a_drive = drv_v[0];
   assign b_dout = dout_v[1]; assign b_drive = drv_v[1];
   assign c_dout = dout_v[2]; assign c_drive = drv_v[2];

   // R7
   a_route_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !a_oe_n |-> a_dout == (a_sel ? sto_v[2] : sto_v[1]));

   // R8
   broadcast_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (!b_oe_n && !c_oe_n && b_sel && !c_sel) |-> b_dout == c_dout);

   // R9
   park_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (a_oe_n || b_oe_n || c_oe_n) |->
         ($countones({a_drive, b_drive, c_drive}) < 3));

   // R3
   hold_after_le_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (!a_le && $past(a_le) && !b_oe_n && b_sel) |-> b_dout == $past(a_din));

endmodule

// File: tb/tb_tri_port_exchanger.sv
module tb_tri_port_exchanger;

   localparam int W = 16;

   logic clk = 1'b0;
   logic rst_n;
   always #4 clk = ~clk;

   logic [W-1:0] din  [3];
   logic         le   [3];
   logic         pclk [3];
   logic         ce_n [3];
   logic         sel  [3];
   logic         oe_n [3];
   logic [W-1:0] dout [3];
   logic         drv  [3];

   // stimulus staging, applied at the negedge
   logic [W-1:0] s_din  [3];
   logic         s_le   [3];
   logic         s_pclk [3];
   logic         s_ce_n [3];
   logic         s_sel  [3];
   logic         s_oe_n [3];
   logic         s_rst_n;

   int checks = 0;
   int failures = 0;
   bit done = 1'b0;

   tri_port_exchanger #(.W(W)) dut (
      .clk(clk), .rst_n(rst_n),
      .a_din(din[0]), .a_le(le[0]), .a_pclk(pclk[0]), .a_ce_n(ce_n[0]),
      .a_sel(sel[0]), .a_oe_n(oe_n[0]), .a_dout(dout[0]), .a_drive(drv[0]),
      .b_din(din[1]), .b_le(le[1]), .b_pclk(pclk[1]), .b_ce_n(ce_n[1]),
      .b_sel(sel[1]), .b_oe_n(oe_n[1]), .b_dout(dout[1]), .b_drive(drv[1]),
      .c_din(din[2]), .c_le(le[2]), .c_pclk(pclk[2]), .c_ce_n(ce_n[2]),
      .c_sel(sel[2]), .c_oe_n(oe_n[2]), .c_dout(dout[2]), .c_drive(drv[2])
   );

   // behavioural model of the stored words and clock history
   logic [W-1:0] m_word [3];
   logic         m_prev [3];

   always @(posedge clk or negedge rst_n) begin
      for (int p = 0; p < 3; p++) begin
         if (!rst_n) begin
            m_word[p] = '0;
            m_prev[p] = 1'b1;
         end else begin
            if (le[p]) m_word[p] = din[p];
            else if (!ce_n[p] && pclk[p] && !m_prev[p]) m_word[p] = din[p];
            m_prev[p] = pclk[p];
         end
      end
   end

   function automatic logic [W-1:0] live(input int s);
      return le[s] ? din[s] : m_word[s];
   endfunction

   task automatic compare(input string tag);
      for (int p = 0; p < 3; p++) begin
         int src;
         logic [W-1:0] exp_d;
         src = sel[p] ? (p + 2) % 3 : (p + 1) % 3;
         exp_d = oe_n[p] ? '0 : live(src);
         checks++;
         if (dout[p] !== exp_d) begin
            failures++;
            $display("FAIL %s port %0d dout actual=%h expected=%h", tag, p, dout[p], exp_d);
         end
         checks++;
         if (drv[p] !== !oe_n[p]) begin
            failures++;
            $display("FAIL %s port %0d drive actual=%b expected=%b", tag, p, drv[p], !oe_n[p]);
         end
      end
   endtask

   task automatic cyc(input string tag);
      @(negedge clk);
      rst_n = s_rst_n;
      for (int p = 0; p < 3; p++) begin
         din[p] = s_din[p]; le[p] = s_le[p]; pclk[p] = s_pclk[p];
         ce_n[p] = s_ce_n[p]; sel[p] = s_sel[p]; oe_n[p] = s_oe_n[p];
      end
      #1;
      compare(tag);
   endtask

   task automatic new_data();
      for (int p = 0; p < 3; p++) s_din[p] = W'($urandom);
   endtask

   task automatic summary();
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
   endtask

   initial begin
      rst_n = 1'b0;
      s_rst_n = 1'b0;
      for (int p = 0; p < 3; p++) begin
         din[p] = '0; le[p] = 1'b0; pclk[p] = 1'b0; ce_n[p] = 1'b1;
         sel[p] = 1'b0; oe_n[p] = 1'b0;
         s_din[p] = 16'hA5A5; s_le[p] = 1'b0; s_pclk[p] = 1'b1; s_ce_n[p] = 1'b0;
         s_sel[p] = 1'b0; s_oe_n[p] = 1'b0;
      end

      // R1: held in reset with a high port clock, outputs show zero words
      repeat (3) cyc("R1");
      s_rst_n = 1'b1;
      // R1: clock high right after reset must not count as a rising edge
      repeat (2) cyc("R1");

      // R2: transparent pass-through, port clocks toggling at the same time
      for (int i = 0; i < 12; i++) begin
         new_data();
         for (int p = 0; p < 3; p++) begin
            s_le[p] = 1'b1; s_pclk[p] = i[0]; s_sel[p] = i[1]; s_ce_n[p] = 1'b0;
         end
         cyc("R2");
      end

      // R3: le falls, inputs keep changing, clocks quiet
      for (int p = 0; p < 3; p++) begin s_le[p] = 1'b0; s_pclk[p] = 1'b0; end
      for (int i = 0; i < 8; i++) begin
         new_data();
         for (int p = 0; p < 3; p++) s_sel[p] = i[0];
         cyc("R3");
      end

      // R4: clocked capture with ce_n low
      for (int i = 0; i < 12; i++) begin
         new_data();
         for (int p = 0; p < 3; p++) begin s_ce_n[p] = 1'b0; s_pclk[p] = i[0]; s_sel[p] = i[2]; end
         cyc("R4");
      end

      // R5: edges with ce_n high are ignored
      for (int i = 0; i < 12; i++) begin
         new_data();
         for (int p = 0; p < 3; p++) begin s_ce_n[p] = 1'b1; s_pclk[p] = i[0]; s_sel[p] = i[1]; end
         cyc("R5");
      end

      // R6: steady clock (high, then low) with ce_n low
      for (int i = 0; i < 10; i++) begin
         new_data();
         for (int p = 0; p < 3; p++) begin s_ce_n[p] = 1'b0; s_pclk[p] = (i < 5); s_sel[p] = i[0]; end
         cyc("R6");
      end

      // R8: port A broadcast to B and C, A transparent then clocked
      for (int i = 0; i < 10; i++) begin
         new_data();
         s_le[0] = (i < 4); s_pclk[0] = i[0]; s_ce_n[0] = 1'b0;
         s_sel[1] = 1'b1; s_sel[2] = 1'b0; s_oe_n[1] = 1'b0; s_oe_n[2] = 1'b0;
         cyc("R8");
      end

      // R7: sweep every select combination with mixed transparency
      for (int i = 0; i < 16; i++) begin
         new_data();
         for (int p = 0; p < 3; p++) begin
            s_sel[p] = i[p]; s_le[p] = (p == (i % 3)); s_oe_n[p] = 1'b0;
         end
         cyc("R7");
      end

      // R9: output enables toggled per port
      for (int i = 0; i < 16; i++) begin
         new_data();
         for (int p = 0; p < 3; p++) begin s_oe_n[p] = i[p]; s_le[p] = i[3]; end
         cyc("R9");
      end

      // R7: random mix of every control
      for (int i = 0; i < 400; i++) begin
         new_data();
         for (int p = 0; p < 3; p++) begin
            s_le[p] = ($urandom % 4) == 0; s_pclk[p] = $urandom % 2;
            s_ce_n[p] = $urandom % 2; s_sel[p] = $urandom % 2;
            s_oe_n[p] = ($urandom % 5) == 0;
         end
         cyc("R7");
      end

      done = 1'b1;
      summary();
      $finish;
   end

   initial begin
      repeat (100000) @(posedge clk);
      if (!done) begin
         failures++;
         $display("FAIL watchdog actual=running expected=finished");
         summary();
         $finish;
      end
   end

endmodule